// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block caches recently used linear-to-physical page translations for 4 KB pages. It sits ahead of a page table walker. Each lookup presents a 32-bit linear address. One cycle later the block reports either a hit or a miss. A hit also returns the physical address: the cached frame number with the untouched page offset appended. It returns the effective write-permission and user-access bits that were cached with the entry, so the caller can check permissions itself.

The storage holds 32 translations, arranged as 8 sets of 4 ways. When the walker finishes, it writes the translation through the fill port. Placement within a set follows a fixed order:
- a way that already holds the same page number is reused;
- otherwise the lowest-numbered empty way is taken;
- otherwise the way chosen by a per-set tree pseudo-LRU is replaced.

Both hits and fills update the tree. A flush input clears every entry in one cycle. It is pulsed whenever the page directory base is reloaded or a task switch happens.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, and `hit_o`, `miss_o` and `paddr_o` are all zero until the first lookup.
- R2: A lookup of a page that is cached raises `hit_o` for exactly the following cycle. In that cycle `paddr_o` equals {stored frame number, address bits 11..0}, and `rw_o` and `us_o` equal the bits stored by the fill.
- R3: A lookup of a page that is not cached raises `miss_o` for exactly the following cycle, with `paddr_o`, `rw_o` and `us_o` all zero.
- R4: Address bits 14..12 select the set and bits 31..15 form the tag. A page with the same set but a different tag misses. A page with the same tag bits but a different set also misses.
- R5: A fill into a set that has empty ways uses the lowest empty way, so four distinct pages filled into one set all stay cached.
- R6: A fill into a full set replaces the tree pseudo-LRU victim. Tree bit 0 means the victim lies in the lower half. Touching a way makes every node on its path point away from it. After fills to ways 0,1,2,3 in that order, the next fill evicts way 0.
- R7: A hit updates the set's tree. After fills to ways 0..3 and then a hit on way 0, the next fill evicts way 2.
- R8: A flush invalidates all 32 entries at the clock edge where it is sampled, so lookups issued afterwards miss.
- R9: A lookup issued in the same cycle as a flush reports a miss, even for a cached page.
- R10: A fill issued in the same cycle as a flush is discarded.
- R11: A fill whose page number is already cached overwrites that entry instead of creating a second copy.
- R12: Every lookup produces exactly one response. `hit_o` and `miss_o` are never high together, and neither is high in a cycle that follows no lookup.
- R13: A lookup that coincides with a fill of the same page sees the contents from before that fill and misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries (directory base reload or task switch) |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | 32 | Linear address to translate |
| hit_o | output | 1 | Previous cycle's lookup hit |
| miss_o | output | 1 | Previous cycle's lookup missed |
| paddr_o | output | 32 | Translated physical address on a hit, zero otherwise |
| rw_o | output | 1 | Stored write-permission bit on a hit |
| us_o | output | 1 | Stored user-access bit on a hit |
| fill_valid_i | input | 1 | Write a completed translation |
| fill_vpn_i | input | 20 | Linear page number being filled |
| fill_pfn_i | input | 20 | Physical frame number being filled |
| fill_rw_i | input | 1 | Effective write-permission bit of the translation |
| fill_us_i | input | 1 | Effective user-access bit of the translation |

## Verification
The bench aims at replacement order. A reversed tree convention, or a hit that does not touch the tree, evicts the wrong page, so a page expected to stay would miss. It fills one page twice. A design that duplicates the page rather than overwriting it returns a stale frame, or loses a different page on the next fill. It issues a flush in the same cycle as a lookup and in the same cycle as a fill. A design that lets the old contents win there would report a hit, or keep a translation that should be gone. It also probes aliasing between set index and tag bits, and a lookup that races a fill of the same page. A wrong bit slice would hit on a foreign page, and a forwarded fill would hit one cycle too early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic rw;
    logic us;
  } perm_t;
endpackage

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam int NODES = WAYS - 1;

  logic [NODES-1:0] tree_q, tree_d;
  int vn, un;

  // bit = 0: victim in lower half; touched path points away
  always_comb begin
    vn = 0;
    for (int l = 0; l < WAY_W; l++) vn = 2 * vn + 1 + int'(tree_q[vn]);
    victim_o = WAY_W'(vn - NODES);
  end

  always_comb begin
    tree_d = tree_q;
    un = 0;
    if (touch_i) begin
      for (int l = 0; l < WAY_W; l++) begin
        tree_d[un] = ~touch_way_i[WAY_W-1-l];
        un = 2 * un + 1 + int'(touch_way_i[WAY_W-1-l]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tree_q <= '0;
    else         tree_q <= tree_d;
  end
endmodule

// File: rtl/tlb_way_pick.sv
module tlb_way_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  match_i,
  input  logic [WAY_W-1:0] plru_i,
  output logic [WAY_W-1:0] way_o
);
  logic found;

  // priority: matching way, lowest empty way, pseudo-LRU victim
  always_comb begin
    way_o = plru_i;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_i[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12,
  parameter int SETS  = 8,
  parameter int WAYS  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   lookup_valid_i,
  input  logic [VA_W-1:0]        lookup_addr_i,
  output logic                   hit_o,
  output logic                   miss_o,
  output logic [PFN_W+OFF_W-1:0] paddr_o,
  output logic                   rw_o,
  output logic                   us_o,
  input  logic                   fill_valid_i,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic                   fill_rw_i,
  input  logic                   fill_us_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PA_W  = PFN_W + OFF_W;

  logic [WAYS-1:0]  vld_q  [SETS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PFN_W-1:0] pfn_q  [SETS][WAYS];
  perm_t            perm_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0]  lk_match, fl_match;
  logic             lk_hit, lk_en, fill_en;
  logic [WAY_W-1:0] lk_way, fl_way;
  logic [WAY_W-1:0] plru_vic [SETS];

  assign lk_idx  = lookup_addr_i[OFF_W +: IDX_W];
  assign lk_tag  = lookup_addr_i[VA_W-1 -: TAG_W];
  assign fl_idx  = fill_vpn_i[IDX_W-1:0];
  assign fl_tag  = fill_vpn_i[VPN_W-1 -: TAG_W];
  assign lk_en   = lookup_valid_i && !flush_i;
  assign fill_en = fill_valid_i && !flush_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    assign fl_match[w] = vld_q[fl_idx][w] && (tag_q[fl_idx][w] == fl_tag);
  end

  assign lk_hit = |lk_match;

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) if (lk_match[w]) lk_way = WAY_W'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             touch;
    logic [WAY_W-1:0] touch_way;
    logic             fill_here;
    assign fill_here = fill_en && (fl_idx == IDX_W'(s));
    // fill owns the tree when both touch one set
    assign touch     = fill_here || (lk_en && lk_hit && (lk_idx == IDX_W'(s)));
    assign touch_way = fill_here ? fl_way : lk_way;

    tlb_plru #(.WAYS(WAYS)) u_plru (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .touch_i    (touch),
      .touch_way_i(touch_way),
      .victim_o   (plru_vic[s])
    );
  end

  tlb_way_pick #(.WAYS(WAYS)) u_pick (
    .valid_i(vld_q[fl_idx]),
    .match_i(fl_match),
    .plru_i (plru_vic[fl_idx]),
    .way_o  (fl_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_en) begin
      vld_q[fl_idx][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en) begin
      tag_q[fl_idx][fl_way]  <= fl_tag;
      pfn_q[fl_idx][fl_way]  <= fill_pfn_i;
      perm_q[fl_idx][fl_way] <= '{rw: fill_rw_i, us: fill_us_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      paddr_o <= '0;
      rw_o    <= 1'b0;
      us_o    <= 1'b0;
    end else begin
      hit_o   <= lk_en && lk_hit;
      miss_o  <= lookup_valid_i && !(lk_en && lk_hit);
      if (lk_en && lk_hit) begin
        paddr_o <= {pfn_q[lk_idx][lk_way], lookup_addr_i[OFF_W-1:0]};
        rw_o    <= perm_q[lk_idx][lk_way].rw;
        us_o    <= perm_q[lk_idx][lk_way].us;
      end else begin
        paddr_o <= PA_W'(0);
        rw_o    <= 1'b0;
        us_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int VA_W  = 32,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic                   lookup_valid_i,
  input logic [VA_W-1:0]        lookup_addr_i,
  input logic                   hit_o,
  input logic                   miss_o,
  input logic [PFN_W+OFF_W-1:0] paddr_o,
  input logic                   rw_o,
  input logic                   us_o
);
  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  a_r12_one_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (hit_o || miss_o));

  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!hit_o && !miss_o));

  a_r9_flush_lookup_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && lookup_valid_i) |=> miss_o);

  a_r8_empty_after_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i) && lookup_valid_i) |=> miss_o);

  a_r3_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (paddr_o == '0 && !rw_o && !us_o));

  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (!hit_o || paddr_o[OFF_W-1:0] == $past(lookup_addr_i[OFF_W-1:0])));
endmodule

bind tlb_cache tlb_cache_chk #(.VA_W(VA_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tlb_cache_test.sv
`timescale 1ns/1ps
module tlb_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_v = 1'b0;
  logic [31:0] lk_a = '0;
  logic        hit, miss, rw, us;
  logic [31:0] pa;
  logic        fl_v = 1'b0;
  logic [19:0] fl_vpn = '0, fl_pfn = '0;
  logic        fl_rw = 1'b0, fl_us = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic        rw;
    logic        us;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  tlb_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lookup_valid_i(lk_v), .lookup_addr_i(lk_a),
    .hit_o(hit), .miss_o(miss), .paddr_o(pa), .rw_o(rw), .us_o(us),
    .fill_valid_i(fl_v), .fill_vpn_i(fl_vpn), .fill_pfn_i(fl_pfn),
    .fill_rw_i(fl_rw), .fill_us_i(fl_us)
  );

  task automatic fail_msg(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n && (hit || miss)) begin
      checks++;
      if (sb.size() == 0) begin
        fail_msg("R12", "unexpected response", {hit, miss}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (hit !== e.hit || miss !== !e.hit || pa !== e.pa || rw !== e.rw || us !== e.us)
          fail_msg(e.req, "hit/pa/rw/us", {hit, pa, rw, us}, {e.hit, e.pa, e.rw, e.us});
      end
    end
  end

  task automatic step(input bit lk, input logic [31:0] la,
                      input bit fv, input logic [19:0] vpn, input logic [19:0] pfn,
                      input bit frw, input bit fus, input bit fsh,
                      input bit ehit, input logic [19:0] epfn, input bit erw, input bit eus,
                      input string req);
    @(negedge clk);
    lk_v = lk; lk_a = la;
    fl_v = fv; fl_vpn = vpn; fl_pfn = pfn; fl_rw = frw; fl_us = fus;
    flush = fsh;
    if (lk) sb.push_back('{hit: ehit, pa: ehit ? {epfn, la[11:0]} : 32'h0,
                           rw: ehit & erw, us: ehit & eus, req: req});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input bit frw, input bit fus);
    step(0, 0, 1, vpn, pfn, frw, fus, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input bit ehit,
                      input logic [19:0] epfn, input bit erw, input bit eus, input string req);
    step(1, {vpn, off}, 0, 0, 0, 0, 0, 0, ehit, epfn, erw, eus, req);
  endtask

  // set index = vpn[2:0]
  function automatic logic [19:0] pg(input logic [16:0] tag, input logic [2:0] set);
    return {tag, set};
  endfunction

  task automatic finish_run();
    repeat (3) idle();
    @(negedge clk);
    checks++;
    if (sb.size() != 0) fail_msg("R12", "missing responses", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (hit !== 0 || miss !== 0 || pa !== 0)
      fail_msg("R1", "outputs after reset", {hit, miss, pa}, 0);

    // R1: empty after reset
    look(pg(17'h00000, 0), 12'h000, 0, 0, 0, 0, "R1");

    // R2: basic hit, several patterns
    fill(pg(17'h12345, 1), 20'hABCDE, 1, 0);
    fill(pg(17'h00FFF, 0), 20'h00001, 0, 1);
    look(pg(17'h12345, 1), 12'h7A5, 1, 20'hABCDE, 1, 0, "R2");
    look(pg(17'h00FFF, 0), 12'hFFF, 1, 20'h00001, 0, 1, "R2");
    look(pg(17'h12345, 1), 12'h000, 1, 20'hABCDE, 1, 0, "R2");

    // R3, R4: aliasing of index and tag
    look(pg(17'h12344, 1), 12'h000, 0, 0, 0, 0, "R4");
    look(pg(17'h12345, 2), 12'h000, 0, 0, 0, 0, "R4");
    look(pg(17'h1FFFF, 7), 12'h123, 0, 0, 0, 0, "R3");

    // R13: same-cycle lookup and fill of one page
    step(1, {pg(17'h00042, 3), 12'h010}, 1, pg(17'h00042, 3), 20'h55555, 1, 1, 0,
         0, 0, 0, 0, "R13");
    look(pg(17'h00042, 3), 12'h010, 1, 20'h55555, 1, 1, "R13");

    // R5, R6: set 5, fills to ways 0..3 then a fifth evicts way 0
    fill(pg(17'h00A00, 5), 20'h0A000, 0, 0);
    fill(pg(17'h00B00, 5), 20'h0B000, 0, 0);
    fill(pg(17'h00C00, 5), 20'h0C000, 0, 0);
    fill(pg(17'h00D00, 5), 20'h0D000, 0, 0);
    look(pg(17'h00A00, 5), 12'h004, 1, 20'h0A000, 0, 0, "R5");
    look(pg(17'h00B00, 5), 12'h004, 1, 20'h0B000, 0, 0, "R5");
    look(pg(17'h00C00, 5), 12'h004, 1, 20'h0C000, 0, 0, "R5");
    look(pg(17'h00D00, 5), 12'h004, 1, 20'h0D000, 0, 0, "R5");
    // lookups in order a,b,c,d leave victim at way 0 again
    fill(pg(17'h00E00, 5), 20'h0E000, 1, 1);
    look(pg(17'h00A00, 5), 12'h008, 0, 0, 0, 0, "R6");
    look(pg(17'h00E00, 5), 12'h008, 1, 20'h0E000, 1, 1, "R6");
    look(pg(17'h00D00, 5), 12'h008, 1, 20'h0D000, 0, 0, "R6");

    // R7: set 6, hit on way 0 moves victim to way 2
    fill(pg(17'h01A00, 6), 20'h1A000, 0, 0);
    fill(pg(17'h01B00, 6), 20'h1B000, 0, 0);
    fill(pg(17'h01C00, 6), 20'h1C000, 0, 0);
    fill(pg(17'h01D00, 6), 20'h1D000, 0, 0);
    look(pg(17'h01A00, 6), 12'h000, 1, 20'h1A000, 0, 0, "R7");
    fill(pg(17'h01E00, 6), 20'h1E000, 0, 1);
    look(pg(17'h01C00, 6), 12'h000, 0, 0, 0, 0, "R7");
    look(pg(17'h01A00, 6), 12'h000, 1, 20'h1A000, 0, 0, "R7");
    look(pg(17'h01B00, 6), 12'h000, 1, 20'h1B000, 0, 0, "R7");
    look(pg(17'h01D00, 6), 12'h000, 1, 20'h1D000, 0, 0, "R7");
    look(pg(17'h01E00, 6), 12'h000, 1, 20'h1E000, 0, 1, "R7");

    // R11: refill of a cached page overwrites it
    fill(pg(17'h02A00, 7), 20'h2A001, 0, 0);
    fill(pg(17'h02B00, 7), 20'h2B000, 0, 0);
    fill(pg(17'h02C00, 7), 20'h2C000, 0, 0);
    fill(pg(17'h02A00, 7), 20'h2A009, 1, 1);
    fill(pg(17'h02D00, 7), 20'h2D000, 0, 0);
    look(pg(17'h02A00, 7), 12'h111, 1, 20'h2A009, 1, 1, "R11");
    look(pg(17'h02B00, 7), 12'h111, 1, 20'h2B000, 0, 0, "R11");
    look(pg(17'h02C00, 7), 12'h111, 1, 20'h2C000, 0, 0, "R11");
    look(pg(17'h02D00, 7), 12'h111, 1, 20'h2D000, 0, 0, "R11");

    // R9: lookup with flush misses; R8: all entries gone
    step(1, {pg(17'h12345, 1), 12'h000}, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
    look(pg(17'h00FFF, 0), 12'h000, 0, 0, 0, 0, "R8");
    look(pg(17'h02D00, 7), 12'h000, 0, 0, 0, 0, "R8");
    look(pg(17'h00E00, 5), 12'h000, 0, 0, 0, 0, "R8");

    // R10: fill with flush dropped
    step(0, 0, 1, pg(17'h03300, 2), 20'h33333, 1, 1, 1, 0, 0, 0, 0, "");
    look(pg(17'h03300, 2), 12'h000, 0, 0, 0, 0, "R10");
    fill(pg(17'h03300, 2), 20'h33334, 0, 1);
    look(pg(17'h03300, 2), 12'h020, 1, 20'h33334, 0, 1, "R10");

    finish_run();
  end
endmodule